// File: doc/BRIEF.md
# Register Scoreboard Dependence Checker

This block tracks, for every architectural register, a single bit that says whether the register holds a settled value. It also decides whether the instruction now in decode may leave that stage. The decode side presents an instruction with two source register numbers and a destination register number, each with its own use flag. The writeback side presents a write enable and a register number.

An instruction issues in a cycle where `dec_valid` is high and `stall` is low. If that instruction writes a register, the register's bit is cleared. A later writeback sets the bit again. The check is deliberately conservative. An instruction stalls if any register it names is pending, and that includes its destination. Write-after-read and write-after-write cases therefore stall exactly like read-after-write cases.

Back-pressure on decode works like this. `dec_valid` acts as the valid of a one-way handshake and `!stall` acts as its ready. While `stall` is high, the upstream stage must hold all decode fields unchanged. Nothing is consumed and no bit changes because of that instruction. The writeback port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset, every bit of `valid_bits` reads 1.
- R2: Register 0 is always treated as valid, and bit 0 of `valid_bits` stays 1 even when an issuing instruction names register 0 as its destination.
- R3: In a cycle with `dec_valid`=1, `stall`=0 and `dst_en`=1 (destination not 0), bit `dst` of `valid_bits` reads 0 after the next rising edge.
- R4: With `dec_valid`=1, `stall` is 1 in the same cycle if any enabled source (`src_a`, `src_b`) or the enabled destination names a register whose bit is 0 and is not being written back in that cycle. This covers a pending destination (write-after-write) as well as a pending source.
- R5: `stall` is 0 when `dec_valid`=0. A register field whose use flag is 0 has no effect on `stall`, even if that register is pending.
- R6: A writeback with `wb_en`=1 sets bit `wb_reg` of `valid_bits` to 1 after the next rising edge.
- R7: A writeback to register r in the same cycle that decode checks r makes r count as valid for that cycle's stall decision.
- R8: If an issue clears register r in the same cycle that writeback sets r, bit r reads 0 after the edge.
- R9: A stalled instruction clears no bit. With `stall`=1 and `wb_en`=0, `valid_bits` is unchanged after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| src_a | input | IDX_W | First source register number |
| src_a_en | input | 1 | First source is read |
| src_b | input | IDX_W | Second source register number |
| src_b_en | input | 1 | Second source is read |
| dst | input | IDX_W | Destination register number |
| dst_en | input | 1 | Instruction writes `dst` |
| wb_en | input | 1 | Writeback completes this cycle |
| wb_reg | input | IDX_W | Register being written back |
| stall | output | 1 | Decode instruction must be held (not-ready) |
| valid_bits | output | NUM_REGS | Current valid bit of every register |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. In one, writeback releases a register in exactly the cycle that decode tests it. In the other, an issue and a writeback target the same register. Both require a register to be pending first, and then the right two sides presented together. Directed sequences build this up by issuing a writer, then combining a writeback with a dependent decode. Random stimulus confined to eight registers keeps pending bits common, so collisions also arise naturally.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_DEF_REGS = 32;

  // Register fields of a decode request, examined in this order.
  typedef enum logic [1:0] {
    FLD_SRC_A = 2'd0,
    FLD_SRC_B = 2'd1,
    FLD_DST   = 2'd2
  } sb_field_e;

  localparam int SB_NUM_FIELDS = 3;
endpackage

// File: rtl/sb_bit_array.sv
module sb_bit_array #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] bits
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits[r] <= 1'b1;
      else if (clr_vec[r]) bits[r] <= 1'b0;   // clear has priority
      else if (set_vec[r]) bits[r] <= 1'b1;
    end
  end
endmodule

// File: rtl/sb_check.sv
module sb_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] bits,
  input  logic                wb_en,
  input  logic [IDX_W-1:0]    wb_reg,
  input  logic                dec_valid,
  input  logic [IDX_W-1:0]    fld_idx [SB_NUM_FIELDS],
  input  logic                fld_en  [SB_NUM_FIELDS],
  output logic                stall
);
  logic [NUM_REGS-1:0] eff_valid;
  logic [NUM_REGS-1:0] needed;
  logic [SB_NUM_FIELDS-1:0] fld_hit [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    // writeback in the same cycle counts as valid for the decision
    if (r == 0) begin : g_zero
      assign eff_valid[r] = 1'b1;
    end else begin : g_other
      assign eff_valid[r] = bits[r] | (wb_en && wb_reg == IDX_W'(r));
    end
    for (genvar f = 0; f < SB_NUM_FIELDS; f++) begin : g_fld
      assign fld_hit[r][f] = fld_en[f] && fld_idx[f] == IDX_W'(r);
    end
    assign needed[r] = |fld_hit[r];
  end

  assign stall = dec_valid && |(needed & ~eff_valid);
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = SB_DEF_REGS,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_valid,
  input  logic [IDX_W-1:0]    src_a,
  input  logic                src_a_en,
  input  logic [IDX_W-1:0]    src_b,
  input  logic                src_b_en,
  input  logic [IDX_W-1:0]    dst,
  input  logic                dst_en,
  input  logic                wb_en,
  input  logic [IDX_W-1:0]    wb_reg,
  output logic                stall,
  output logic [NUM_REGS-1:0] valid_bits
);
  logic [IDX_W-1:0]    fld_idx [SB_NUM_FIELDS];
  logic                fld_en  [SB_NUM_FIELDS];
  logic [NUM_REGS-1:0] set_vec;
  logic [NUM_REGS-1:0] clr_vec;
  logic                issue_wr;

  always_comb begin
    fld_idx[FLD_SRC_A] = src_a;  fld_en[FLD_SRC_A] = src_a_en;
    fld_idx[FLD_SRC_B] = src_b;  fld_en[FLD_SRC_B] = src_b_en;
    fld_idx[FLD_DST]   = dst;    fld_en[FLD_DST]   = dst_en;
  end

  sb_check #(.NUM_REGS(NUM_REGS)) u_check (
    .bits      (valid_bits),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .dec_valid (dec_valid),
    .fld_idx   (fld_idx),
    .fld_en    (fld_en),
    .stall     (stall)
  );

  // a bit is cleared only in the cycle its writer actually leaves decode
  assign issue_wr = dec_valid && !stall && dst_en;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_upd
    if (r == 0) begin : g_zero
      assign set_vec[r] = 1'b0;
      assign clr_vec[r] = 1'b0;
    end else begin : g_other
      assign set_vec[r] = wb_en && wb_reg == IDX_W'(r);
      assign clr_vec[r] = issue_wr && dst == IDX_W'(r);
    end
  end

  sb_bit_array #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .bits    (valid_bits)
  );
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dec_valid,
  input logic [IDX_W-1:0]    dst,
  input logic                dst_en,
  input logic                wb_en,
  input logic [IDX_W-1:0]    wb_reg,
  input logic                stall,
  input logic [NUM_REGS-1:0] valid_bits
);
  // R2
  zero_reg_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_bits[0]);

  // R5
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dec_valid);

  // R3
  issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall && dst_en && dst != '0) |=> !valid_bits[$past(dst)]);

  // R6
  wb_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_reg != '0 && !(dec_valid && !stall && dst_en && dst == wb_reg))
      |=> valid_bits[$past(wb_reg)]);

  // R9
  stalled_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !wb_en) |=> valid_bits == $past(valid_bits));
endmodule

bind reg_scoreboard sb_chk #(.NUM_REGS(NUM_REGS)) u_sb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_valid  (dec_valid),
  .dst        (dst),
  .dst_en     (dst_en),
  .wb_en      (wb_en),
  .wb_reg     (wb_reg),
  .stall      (stall),
  .valid_bits (valid_bits)
);

// File: tb/sim_reg_scoreboard.sv
module sim_reg_scoreboard;
  localparam int N = 32;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, src_a_en = 1'b0, src_b_en = 1'b0, dst_en = 1'b0, wb_en = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0, dst = '0, wb_reg = '0;
  logic stall;
  logic [N-1:0] valid_bits;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '1;

  always #5 clk = ~clk;

  reg_scoreboard #(.NUM_REGS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
    .src_a(src_a), .src_a_en(src_a_en), .src_b(src_b), .src_b_en(src_b_en),
    .dst(dst), .dst_en(dst_en), .wb_en(wb_en), .wb_reg(wb_reg),
    .stall(stall), .valid_bits(valid_bits)
  );

  function automatic logic eff(input logic [W-1:0] r);
    return (r == '0) || model[r] || (wb_en && wb_reg == r);
  endfunction

  function automatic logic exp_stall();
    return dec_valid && ((src_a_en && !eff(src_a)) ||
                         (src_b_en && !eff(src_b)) ||
                         (dst_en && !eff(dst)));
  endfunction

  function automatic logic [N-1:0] exp_next(input logic st);
    logic [N-1:0] nx;
    nx = model;
    if (wb_en) nx[wb_reg] = 1'b1;
    if (dec_valid && !st && dst_en) nx[dst] = 1'b0;
    nx[0] = 1'b1;
    return nx;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stall act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid_bits act=%h exp=%h", tag, act, exp);
    end
  endtask

  // inputs are driven after the falling edge; checks land 1 ns later
  task automatic step(input string tag,
                      input logic dv, input logic [W-1:0] a, input logic ae,
                      input logic [W-1:0] b, input logic be,
                      input logic [W-1:0] d, input logic de,
                      input logic we, input logic [W-1:0] wr);
    logic es;
    logic [N-1:0] nx;
    @(negedge clk);
    dec_valid = dv; src_a = a; src_a_en = ae; src_b = b; src_b_en = be;
    dst = d; dst_en = de; wb_en = we; wb_reg = wr;
    #1;
    es = exp_stall();
    check_bit(tag, stall, es);
    nx = exp_next(es);
    @(posedge clk);
    #1;
    model = nx;
    check_vec(tag, valid_bits, model);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check_vec("R1", valid_bits, '1);
    rst_n = 1'b1;

    // R5: no request means no stall
    step("R5", 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    // R3: writer of r5 issues and clears it
    step("R3", 1'b1, 5'd1, 1'b1, 5'd2, 1'b1, 5'd5, 1'b1, 1'b0, 5'd0);
    // R4: read of pending r5 stalls
    step("R4", 1'b1, 5'd5, 1'b1, 5'd2, 1'b1, 5'd7, 1'b1, 1'b0, 5'd0);
    // R9: stalled write-after-write keeps all bits
    step("R9", 1'b1, 5'd1, 1'b0, 5'd2, 1'b0, 5'd5, 1'b1, 1'b0, 5'd0);
    // R5: disabled field naming pending r5 is ignored
    step("R5", 1'b1, 5'd5, 1'b0, 5'd5, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
    // R7: writeback of r5 lets a reader of r5 pass in the same cycle
    step("R7", 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 5'd9, 1'b1, 1'b1, 5'd5);
    // R6: writeback releases r9
    step("R6", 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd9);
    // R8: issue clears r6 while nothing sets it, then clear and set collide
    step("R8", 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, 1'b0, 5'd0);
    step("R8", 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, 1'b1, 5'd6);
    // R2: writing register 0 never clears it
    step("R2", 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0);
    step("R2", 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);

    for (int i = 0; i < 3000; i++) begin
      step("R4", ($urandom % 4) != 0,
           W'($urandom % 8), $urandom % 2 == 0,
           W'($urandom % 8), $urandom % 2 == 0,
           W'($urandom % 8), $urandom % 3 != 0,
           $urandom % 5 < 2, W'($urandom % 8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule